// File: doc/BRIEF.md
# Tick-Paced Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver. It has no baud divider of its own. A separate counter/timer supplies a one-cycle `tick` at sixteen times the bit rate, and every bit period in both directions lasts exactly sixteen of those ticks. Software-side logic writes a byte through a strobe-qualified write port and watches `tx_busy`. Received bytes appear on `rx_data` together with a one-cycle `rx_valid` strobe.

Every transmitted frame has one low start bit, then eight bit slots sent least significant bit first, then two high stop bits. The receiver needs only one stop bit. The single `par_en` control switches both directions into odd-parity mode. In that mode the transmitter replaces the top data bit with an odd parity bit. The receiver replaces the top bit of the delivered byte with a parity-error flag. Each direction has a one-cycle interrupt request pulse for every character it completes.

Top module: `tick_uart`

## Requirements
- R1: After reset, `txd` is high, `tx_busy` is low, and `tx_irq`, `rx_irq` and `rx_valid` are low.
- R2: When `tx_wr` is high while `tx_busy` is low, the write is accepted. In the next cycle `tx_busy` is high and `txd` goes low for the start bit. Eight slots then follow, bit 0 first, and then two high stop bits. Each bit lasts 16 ticks.
- R3: With `par_en` low at the write, the eight slots carry `tx_data[7:0]` unchanged.
- R4: With `par_en` high at the write, slots 0 to 6 carry `tx_data[6:0]`. Slot 7 carries the odd parity bit of those seven bits, so the eight slots hold an odd number of ones.
- R5: A `tx_wr` while `tx_busy` is high is ignored. The frame in progress continues unchanged, and no extra frame is sent.
- R6: At the end of the second stop bit, `tx_irq` pulses for exactly one cycle, in the same cycle that `tx_busy` falls. A write presented in that cycle is accepted.
- R7: A frame on `rxd` is accepted and delivered on `rx_data`. The frame is a low start bit, eight bits LSB first and one high stop bit, each sampled near its midpoint. Delivery comes with a one-cycle pulse on both `rx_valid` and `rx_irq`.
- R8: With `par_en` high at delivery, `rx_data[6:0]` are the received bits 0 to 6. `rx_data[7]` is 1 when the eight received slots contain an even number of ones (a parity error), and 0 otherwise.
- R9: A low pulse on `rxd` that has returned high by the middle of the start bit is discarded, with no strobe. A following valid frame is still received correctly.
- R10: A frame whose stop bit is sampled low is discarded, with no strobe.
- R11: While transmitting, `txd` changes only in the cycle after a `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 16x the bit rate |
| par_en | input | 1 | Odd-parity mode for both directions |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Transmitter is sending a frame |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` updated |
| tx_irq | output | 1 | One-cycle transmit-done request |
| rx_irq | output | 1 | One-cycle receive-done request |

## Verification
Two transmitter events can fall in the same cycle: the end of one frame and the acceptance of the next write. The bench waits for the cycle in which `tx_irq` is high. In that same cycle it presents a new byte on `tx_wr`. The bench then checks three things: `tx_busy` was already low in that cycle, both frames appear complete on the line, and two transmit interrupts are counted. A separate case presents a write in mid-frame and confirms that no extra frame follows.

// File: rtl/tick_uart.sv
module tick_uart #(
  parameter int OSR      = 16,
  parameter int NBITS    = 8,
  parameter int TX_STOPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             par_en,
  input  logic             tx_wr,
  input  logic [NBITS-1:0] tx_data,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  output logic [NBITS-1:0] rx_data,
  output logic             rx_valid,
  output logic             tx_irq,
  output logic             rx_irq
);
  localparam int CW    = $clog2(OSR);
  localparam int FRAME = NBITS + 1 + TX_STOPS;
  localparam int FW    = $clog2(FRAME + 1);
  localparam int BW    = $clog2(NBITS + 1);
  localparam int MID   = OSR / 2 - 1;

  // transmitter
  logic [FRAME-1:0] tsh;
  logic [CW-1:0]    tcnt;
  logic [FW-1:0]    tidx;
  logic [NBITS-1:0] tpay;
  logic             tbit_end;

  always_comb begin
    tpay = tx_data;
    if (par_en) tpay[NBITS-1] = ~^tx_data[NBITS-2:0];
  end

  assign tbit_end = tick && (tcnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsh     <= '1;
      tcnt    <= '0;
      tidx    <= '0;
      tx_busy <= 1'b0;
      tx_irq  <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      if (!tx_busy) begin
        if (tx_wr) begin
          tsh     <= {{TX_STOPS{1'b1}}, tpay, 1'b0};
          tcnt    <= '0;
          tidx    <= '0;
          tx_busy <= 1'b1;
        end
      end else if (tick) begin
        tcnt <= tbit_end ? '0 : tcnt + 1'b1;
        if (tbit_end) begin
          if (tidx == FW'(FRAME - 1)) begin
            tx_busy <= 1'b0;
            tx_irq  <= 1'b1;
          end else begin
            tsh  <= {1'b1, tsh[FRAME-1:1]};
            tidx <= tidx + 1'b1;
          end
        end
      end
    end
  end

  assign txd = tx_busy ? tsh[0] : 1'b1;

  // receiver
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rstate_t;
  rstate_t          rst_q;
  logic [1:0]       rsync;
  logic             rs;
  logic [CW-1:0]    rcnt;
  logic [BW-1:0]    ridx;
  logic [NBITS-1:0] rsh;
  logic             rbit_end;

  assign rs       = rsync[1];
  assign rbit_end = tick && (rcnt == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync    <= 2'b11;
      rst_q    <= R_IDLE;
      rcnt     <= '0;
      ridx     <= '0;
      rsh      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rsync    <= {rsync[0], rxd};
      rx_valid <= 1'b0;
      case (rst_q)
        R_IDLE: if (tick && !rs) begin
          rst_q <= R_START;
          rcnt  <= '0;
        end
        R_START: if (tick) begin
          if (rcnt == CW'(MID)) begin
            rcnt <= '0;
            ridx <= '0;
            rst_q <= rs ? R_IDLE : R_DATA;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        R_DATA: if (tick) begin
          rcnt <= rbit_end ? '0 : rcnt + 1'b1;
          if (rbit_end) begin
            rsh <= {rs, rsh[NBITS-1:1]};
            if (ridx == BW'(NBITS - 1)) rst_q <= R_STOP;
            else ridx <= ridx + 1'b1;
          end
        end
        R_STOP: if (tick) begin
          rcnt <= rbit_end ? '0 : rcnt + 1'b1;
          if (rbit_end) begin
            rst_q <= R_IDLE;
            if (rs) begin
              rx_valid <= 1'b1;
              rx_data  <= par_en ? {~^rsh, rsh[NBITS-2:0]} : rsh;
            end
          end
        end
        default: rst_q <= R_IDLE;
      endcase
    end
  end

  assign rx_irq = rx_valid;
endmodule

module tick_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic tx_wr,
  input logic tx_busy,
  input logic txd,
  input logic tx_irq,
  input logic rx_valid
);
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !tx_busy |=> tx_busy && !txd);

  p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> tx_irq);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  p_rx_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_tick_paced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy && !tick |=> tx_busy && $stable(txd));
endmodule

bind tick_uart tick_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_wr(tx_wr), .tx_busy(tx_busy),
  .txd(txd), .tx_irq(tx_irq), .rx_valid(rx_valid)
);

// File: tb/sim_tick_uart.sv
`timescale 1ns/1ps
module sim_tick_uart;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic par_en = 1'b0;
  logic tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_busy, txd;
  logic rxd = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, tx_irq, rx_irq;

  int vectors = 0;
  int fails = 0;
  int tx_irq_cnt = 0;
  int tx_frames_exp = 0;
  int rx_cnt = 0;
  int rx_exp = 0;
  bit done = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [1:0] tdiv = 2'd0;

  localparam int BITCLK = 64;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  tick_uart u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tx_write(input logic [7:0] d, input bit expect_accept);
    @(negedge clk);
    tx_data = d;
    tx_wr = 1'b1;
    if (expect_accept) begin
      txq.push_back(par_en ? {~^d[6:0], d[6:0]} : d);
      tx_frames_exp++;
    end
    @(negedge clk);
    tx_wr = 1'b0;
    chk(tx_busy == 1'b1, "R2 busy after write", tx_busy, 1);
  endtask

  task automatic send_rx(input logic [7:0] raw, input bit good_stop);
    if (good_stop) begin
      rxq.push_back(par_en ? {~^raw, raw[6:0]} : raw);
      rx_exp++;
    end
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = raw[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = good_stop;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
  endtask

  // transmit line monitor
  initial begin
    logic [7:0] got;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        repeat (BITCLK / 2) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITCLK) @(negedge clk);
          got[i] = txd;
        end
        for (int s = 0; s < 2; s++) begin
          repeat (BITCLK) @(negedge clk);
          chk(txd == 1'b1, "R2 stop bit", txd, 1);
        end
        if (txq.size() == 0) begin
          chk(1'b0, "R5 unexpected tx frame", got, 0);
        end else begin
          exp = txq.pop_front();
          chk(got == exp, "R3/R4 tx slots", got, exp);
        end
      end
    end
  end

  // receive monitor and interrupt counters
  always @(negedge clk) begin
    if (tx_irq) tx_irq_cnt++;
    if (rx_valid) begin
      rx_cnt++;
      chk(rx_irq == 1'b1, "R7 rx_irq with rx_valid", rx_irq, 1);
      if (rxq.size() == 0) chk(1'b0, "R9/R10 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = rxq.pop_front();
        chk(rx_data == e, "R7/R8 rx byte", rx_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(txd == 1'b1, "R1 txd reset", txd, 1);
    chk(tx_busy == 1'b0, "R1 busy reset", tx_busy, 0);
    chk({tx_irq, rx_irq, rx_valid} == 3'b000, "R1 strobes reset", {tx_irq, rx_irq, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd == 1'b1 && tx_busy == 1'b0, "R1 idle after reset", {tx_busy, txd}, 1);

    // R3: plain data
    par_en = 1'b0;
    tx_write(8'hA5, 1'b1);
    repeat (800) @(negedge clk);
    tx_write(8'h81, 1'b1);
    // R5: write while busy is ignored
    repeat (100) @(negedge clk);
    chk(tx_busy == 1'b1, "R5 busy before ignored write", tx_busy, 1);
    tx_write(8'h3C, 1'b0);
    repeat (800) @(negedge clk);
    chk(tx_busy == 1'b0, "R6 idle after frame", tx_busy, 0);

    // R4: parity mode
    par_en = 1'b1;
    tx_write(8'h07, 1'b1);
    repeat (800) @(negedge clk);
    tx_write(8'hF3, 1'b1);

    // R6: write in the cycle the previous frame ends
    forever begin
      @(negedge clk);
      if (tx_irq) break;
    end
    chk(tx_busy == 1'b0, "R6 busy low with tx_irq", tx_busy, 0);
    tx_data = 8'h5A;
    tx_wr = 1'b1;
    txq.push_back({~^tx_data[6:0], tx_data[6:0]});
    tx_frames_exp++;
    @(negedge clk);
    tx_wr = 1'b0;
    chk(tx_busy == 1'b1, "R6 back-to-back accepted", tx_busy, 1);
    chk(tx_irq == 1'b0, "R6 single-cycle irq", tx_irq, 0);
    repeat (800) @(negedge clk);

    // receive path
    par_en = 1'b0;
    send_rx(8'h96, 1'b1);
    send_rx(8'h01, 1'b1);
    par_en = 1'b1;
    send_rx(8'h83, 1'b1);   // R8 odd ones: flag 0
    send_rx(8'h03, 1'b1);   // R8 even ones: flag 1
    par_en = 1'b0;
    // R9: short glitch
    @(negedge clk);
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk(rx_cnt == rx_exp, "R9 glitch discarded", rx_cnt, rx_exp);
    send_rx(8'h4E, 1'b1);
    // R10: bad stop bit
    send_rx(8'hC3, 1'b0);
    repeat (200) @(negedge clk);
    chk(rx_cnt == rx_exp, "R10 bad stop discarded", rx_cnt, rx_exp);
    send_rx(8'h2D, 1'b1);

    repeat (400) @(negedge clk);
    chk(txq.size() == 0, "R2 all tx frames seen", txq.size(), 0);
    chk(rxq.size() == 0, "R7 all rx bytes seen", rxq.size(), 0);
    chk(tx_irq_cnt == tx_frames_exp, "R6 tx_irq count", tx_irq_cnt, tx_frames_exp);
    chk(rx_cnt == rx_exp, "R7 rx strobe count", rx_cnt, rx_exp);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule